// File: doc/BRIEF.md
# I2C Slave Controller with Clock Stretching

This block is the slave side of a two-wire serial bus, sitting beside a small processor core. It watches the clock and data lines through synchronizers and pulls either line low through open-drain enables. Once a start condition appears, it shifts in a 7-bit address, most significant bit first, and compares it with a programmable own address. The eighth bit gives the transfer direction. On a match it acknowledges in the ninth clock, flags the match and then holds the clock low.

After every address match and every completed data byte, the slave keeps the clock stretched and raises one interrupt. Software tells the two causes apart with the match flag. Software then services the data register to let the bus go on. In transmit mode it writes the next byte, and in receive mode it reads the received byte, which may be a dummy read. When receiving, the ninth-clock acknowledge comes from a software-set value. When transmitting, the master's acknowledge is captured, and a negative acknowledge makes the slave let go of the data line and wait for a stop condition.

Top module: `i2c_slave_stretch`

## Requirements
- R1: After reset, scl_oe, sda_oe, irq, bus_busy, addr_hit, rw_flag and rx_nack are all 0.
- R2: A falling SDA while SCL is high (start) sets bus_busy. A rising SDA while SCL is high (stop) clears bus_busy and releases both lines.
- R3: The first byte after a start is taken MSB first. If its upper 7 bits equal own_addr, the slave copies bit 0 to rw_flag (1 = master reads), pulls SDA low during the ninth clock and sets addr_hit.
- R4: If the address does not match, the slave never pulls SDA, raises no irq and leaves addr_hit at 0 until the next start, including during later bytes.
- R5: After the address acknowledge the slave holds SCL low (scl_oe=1) with irq=1. Only dr_wr releases it when tx_mode=1, and only dr_rd releases it when tx_mode=0. The other access leaves SCL held.
- R6: In receive mode each byte is assembled MSB first and shown on dr_rdata. During its ninth clock SDA carries ack_val, where 0 means SDA is pulled low.
- R7: At the end of each acknowledged data byte the slave holds SCL low, raises irq and clears addr_hit.
- R8: In transmit mode the byte from dr_wdata is sent MSB first. sda_oe only starts pulling while SCL is low.
- R9: In transmit mode the SDA level in the ninth clock is stored in rx_nack. If it is 1, the slave does not stretch, irq stays 0 and SDA stays released until the next start or stop.
- R10: While en=0 the slave ignores the bus (no acknowledge, bus_busy 0). Clearing en releases both lines and irq in the next cycle, and this takes priority over a data-register access in the same cycle.
- R11: A start in the middle of a byte abandons it and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled clock line |
| sda_i | input | 1 | Sampled data line |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| en | input | 1 | Interface enable |
| tx_mode | input | 1 | 1 = slave sends data, 0 = slave receives |
| ack_val | input | 1 | Acknowledge level sent after a received byte |
| own_addr | input | 7 | Own slave address |
| dr_wdata | input | 8 | Byte written to the data register |
| dr_wr | input | 1 | Data register write strobe |
| dr_rd | input | 1 | Data register read strobe |
| dr_rdata | output | 8 | Last received byte |
| rw_flag | output | 1 | Direction bit of the matched address |
| addr_hit | output | 1 | Address matched, cleared on byte completion |
| rx_nack | output | 1 | Acknowledge level seen from the master |
| bus_busy | output | 1 | Bus between start and stop |
| irq | output | 1 | Service request, high while clock is stretched |

## Verification
Two actions can meet in one cycle while the clock is stretched: software dropping the enable, and software writing the data register in transmit mode. The bench makes both happen on the same clock edge, using a byte whose top bit is 0 so that an accepted write would pull SDA low. It then checks that SCL is released, SDA stays undriven and the busy flag drops. The bench also tests an access of the wrong kind during a stretch and checks that SCL stays held.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = ADDR_W + 1;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_HOLD,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_TACK,
    ST_MUTE
  } st_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise  = scl_s & ~scl_q;
    scl_fall  = ~scl_s & scl_q;
    start_det = scl_s & scl_q & sda_q & ~sda_s;
    stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  end
endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tx_mode,
  input  logic              ack_val,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] dr_wdata,
  input  logic              dr_wr,
  input  logic              dr_rd,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_drv,
  output logic              scl_hold,
  output logic [BYTE_W-1:0] rdata,
  output logic              rw,
  output logic              hit,
  output logic              nack,
  output logic              busy
);
  st_e               st, n_st;
  logic [CNT_W-1:0]  cnt, n_cnt;
  logic [BYTE_W-1:0] sr, n_sr, n_rdata;
  logic              n_rw, n_hit, n_nack, n_busy, n_sda, n_hold;
  logic              service;

  assign service = tx_mode ? dr_wr : dr_rd;

  always_comb begin
    n_st    = st;
    n_cnt   = cnt;
    n_sr    = sr;
    n_rdata = rdata;
    n_rw    = rw;
    n_hit   = hit;
    n_nack  = nack;
    n_busy  = busy;
    n_sda   = sda_drv;
    n_hold  = scl_hold;
    if (!en) begin
      n_st   = ST_IDLE;
      n_cnt  = '0;
      n_busy = 1'b0;
      n_sda  = 1'b0;
      n_hold = 1'b0;
    end else if (stop_det) begin
      n_st   = ST_IDLE;
      n_busy = 1'b0;
      n_sda  = 1'b0;
      n_hold = 1'b0;
    end else if (start_det) begin
      n_st   = ST_ADDR;
      n_cnt  = '0;
      n_busy = 1'b1;
      n_sda  = 1'b0;
      n_hold = 1'b0;
    end else begin
      unique case (st)
        ST_ADDR: begin
          if (scl_rise) begin
            n_sr  = {sr[BYTE_W-2:0], sda_s};
            n_cnt = cnt + 1'b1;
          end else if (scl_fall && cnt == CNT_FULL) begin
            if (sr[BYTE_W-1:1] == own_addr) begin
              n_rw  = sr[0];
              n_hit = 1'b1;
              n_sda = 1'b1;
              n_st  = ST_AACK;
            end else begin
              n_st  = ST_MUTE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            n_sda  = 1'b0;
            n_hold = 1'b1;
            n_st   = ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (service) begin
            n_hold = 1'b0;
            n_cnt  = '0;
            if (tx_mode) begin
              n_sr  = dr_wdata;
              n_sda = ~dr_wdata[BYTE_W-1];
              n_st  = ST_TX;
            end else begin
              n_st  = ST_RX;
            end
          end
        end
        ST_RX: begin
          if (scl_rise) begin
            n_sr  = {sr[BYTE_W-2:0], sda_s};
            n_cnt = cnt + 1'b1;
          end else if (scl_fall && cnt == CNT_FULL) begin
            n_rdata = sr;
            n_sda   = ~ack_val;
            n_st    = ST_RACK;
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            n_sda  = 1'b0;
            n_hold = 1'b1;
            n_hit  = 1'b0;
            n_st   = ST_HOLD;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            n_cnt = cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == CNT_FULL) begin
              n_sda = 1'b0;
              n_st  = ST_TACK;
            end else begin
              n_sr  = {sr[BYTE_W-2:0], 1'b0};
              n_sda = ~sr[BYTE_W-2];
            end
          end
        end
        ST_TACK: begin
          if (scl_rise) begin
            n_nack = sda_s;
          end else if (scl_fall) begin
            if (nack) begin
              n_st   = ST_MUTE;
            end else begin
              n_hold = 1'b1;
              n_hit  = 1'b0;
              n_st   = ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      sr       <= '0;
      rdata    <= '0;
      rw       <= 1'b0;
      hit      <= 1'b0;
      nack     <= 1'b0;
      busy     <= 1'b0;
      sda_drv  <= 1'b0;
      scl_hold <= 1'b0;
    end else begin
      st       <= n_st;
      cnt      <= n_cnt;
      sr       <= n_sr;
      rdata    <= n_rdata;
      rw       <= n_rw;
      hit      <= n_hit;
      nack     <= n_nack;
      busy     <= n_busy;
      sda_drv  <= n_sda;
      scl_hold <= n_hold;
    end
  end
endmodule

// File: rtl/i2c_slave_stretch.sv
module i2c_slave_stretch
  import i2cs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              en,
  input  logic              tx_mode,
  input  logic              ack_val,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] dr_wdata,
  input  logic              dr_wr,
  input  logic              dr_rd,
  output logic [BYTE_W-1:0] dr_rdata,
  output logic              rw_flag,
  output logic              addr_hit,
  output logic              rx_nack,
  output logic              bus_busy,
  output logic              irq
);
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  logic [1:0] line_s;
  logic       scl_rise, scl_fall, start_det, stop_det;
  logic       hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  i2cs_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .d({scl_i, sda_i}), .q(line_s)
  );

  i2cs_cond u_cond (
    .clk(clk), .rst_n(rst_core_n), .scl_s(line_s[1]), .sda_s(line_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_fsm u_fsm (
    .clk(clk), .rst_n(rst_core_n), .en(en), .tx_mode(tx_mode),
    .ack_val(ack_val), .own_addr(own_addr), .dr_wdata(dr_wdata),
    .dr_wr(dr_wr), .dr_rd(dr_rd), .sda_s(line_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .sda_drv(sda_oe), .scl_hold(hold), .rdata(dr_rdata),
    .rw(rw_flag), .hit(addr_hit), .nack(rx_nack), .busy(bus_busy)
  );

  assign scl_oe = hold;
  assign irq    = hold;
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic scl_oe,
  input logic sda_oe,
  input logic en,
  input logic dr_wr,
  input logic dr_rd,
  input logic addr_hit,
  input logic bus_busy,
  input logic irq
);
  a_r2_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_busy |-> (!sda_oe && !scl_oe));

  a_r3_hit_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_hit) |-> sda_oe);

  a_r5_hold_until_service: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && en && !dr_wr && !dr_rd) |=> scl_oe);

  a_r8_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_oe && !sda_oe && !irq && !bus_busy));
endmodule

bind i2c_slave_stretch i2cs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .en(en), .dr_wr(dr_wr), .dr_rd(dr_rd), .addr_hit(addr_hit),
  .bus_busy(bus_busy), .irq(irq)
);

// File: tb/test_i2c_slave_stretch.sv
module test_i2c_slave_stretch;
  localparam time CLK_PERIOD = 10ns;
  localparam int  QTR        = 16;
  localparam int  WD_LIMIT   = 150000;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk, rst_n;
  logic scl_m, sda_m;
  logic scl_oe, sda_oe;
  logic en, tx_mode, ack_val;
  logic [6:0] own_addr;
  logic [7:0] dr_wdata, dr_rdata;
  logic dr_wr, dr_rd;
  logic rw_flag, addr_hit, rx_nack, bus_busy, irq;
  wire  scl_line = scl_m & ~scl_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  i2c_slave_stretch i_i2c_slave_stretch (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .en(en), .tx_mode(tx_mode),
    .ack_val(ack_val), .own_addr(own_addr), .dr_wdata(dr_wdata),
    .dr_wr(dr_wr), .dr_rd(dr_rd), .dr_rdata(dr_rdata), .rw_flag(rw_flag),
    .addr_hit(addr_hit), .rx_nack(rx_nack), .bus_busy(bus_busy), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WD_LIMIT) begin
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
        finish_run();
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wq();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wait_scl_high(); wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wait_scl_high(); wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic m_put_bit(input logic b);
    sda_m = b; wq();
    scl_m = 1'b1; wait_scl_high(); wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic m_get_bit(output logic b);
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wait_scl_high(); wq();
    b = sda_line;
    scl_m = 1'b0; wq();
  endtask

  task automatic m_write_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) m_put_bit(d[i]);
    m_get_bit(ack);
  endtask

  task automatic m_read_byte(output logic [7:0] d, input logic ack);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      m_get_bit(b);
      d[i] = b;
    end
    m_put_bit(ack);
  endtask

  task automatic sw_rd();
    @(negedge clk) dr_rd = 1'b1;
    @(negedge clk) dr_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic sw_wr(input logic [7:0] d);
    @(negedge clk) begin dr_wr = 1'b1; dr_wdata = d; end
    @(negedge clk) dr_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "scl_oe", scl_oe, 0);
    chk("R1", "sda_oe", sda_oe, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "bus_busy", bus_busy, 0);
    chk("R1", "addr_hit", addr_hit, 0);
    chk("R1", "rw_flag", rw_flag, 0);
    chk("R1", "rx_nack", rx_nack, 0);
  endtask

  task automatic t_master_write();
    logic ack;
    tx_mode = 1'b0; ack_val = 1'b0;
    m_start();
    chk("R2", "busy after start", bus_busy, 1);
    m_write_byte({OWN, 1'b0}, ack);
    chk("R3", "address ack", ack, 0);
    chk("R3", "addr_hit", addr_hit, 1);
    chk("R3", "rw_flag", rw_flag, 0);
    chk("R5", "irq after match", irq, 1);
    chk("R5", "scl held", scl_oe, 1);
    sw_wr(8'h77);
    chk("R5", "write ignored in rx mode", scl_oe, 1);
    sw_rd();
    chk("R5", "read releases scl", scl_oe, 0);
    m_write_byte(8'hC3, ack);
    chk("R6", "data ack low", ack, 0);
    chk("R6", "rdata C3", dr_rdata, 8'hC3);
    chk("R7", "irq byte done", irq, 1);
    chk("R7", "scl held byte done", scl_oe, 1);
    chk("R7", "addr_hit cleared", addr_hit, 0);
    ack_val = 1'b1;
    sw_rd();
    m_write_byte(8'h3C, ack);
    chk("R6", "software nack", ack, 1);
    chk("R6", "rdata 3C", dr_rdata, 8'h3C);
    ack_val = 1'b0;
    sw_rd();
    m_stop();
    chk("R2", "busy after stop", bus_busy, 0);
    chk("R2", "scl released", scl_oe, 0);
    chk("R2", "sda released", sda_oe, 0);
  endtask

  task automatic t_mismatch();
    logic ack;
    tx_mode = 1'b0;
    m_start();
    m_write_byte({7'h11, 1'b0}, ack);
    chk("R4", "no ack on mismatch", ack, 1);
    chk("R4", "no irq", irq, 0);
    chk("R4", "addr_hit stays 0", addr_hit, 0);
    m_write_byte({OWN, 1'b0}, ack);
    chk("R4", "own address as data ignored", ack, 1);
    chk("R4", "addr_hit after data", addr_hit, 0);
    m_stop();
  endtask

  task automatic t_master_read();
    logic ack;
    logic [7:0] d;
    tx_mode = 1'b1;
    m_start();
    m_write_byte({OWN, 1'b1}, ack);
    chk("R3", "read address ack", ack, 0);
    chk("R3", "rw_flag read", rw_flag, 1);
    sw_rd();
    chk("R5", "read ignored in tx mode", scl_oe, 1);
    sw_wr(8'hA5);
    chk("R5", "write releases scl", scl_oe, 0);
    m_read_byte(d, 1'b0);
    chk("R8", "byte A5", d, 8'hA5);
    chk("R9", "rx_nack ack", rx_nack, 0);
    chk("R7", "irq tx byte done", irq, 1);
    sw_wr(8'h0F);
    m_read_byte(d, 1'b1);
    chk("R8", "byte 0F", d, 8'h0F);
    chk("R9", "rx_nack set", rx_nack, 1);
    chk("R9", "no stretch on nack", scl_oe, 0);
    chk("R9", "no irq on nack", irq, 0);
    chk("R9", "sda released", sda_oe, 0);
    m_stop();
    chk("R2", "busy cleared", bus_busy, 0);
  endtask

  task automatic t_restart_and_disable();
    logic ack;
    tx_mode = 1'b0;
    m_start();
    m_write_byte({OWN, 1'b0}, ack);
    sw_rd();
    m_put_bit(1'b1); m_put_bit(1'b0); m_put_bit(1'b1);
    m_start();
    chk("R11", "busy after restart", bus_busy, 1);
    m_write_byte({OWN, 1'b1}, ack);
    chk("R11", "ack after restart", ack, 0);
    chk("R11", "rw after restart", rw_flag, 1);
    chk("R11", "held after restart", scl_oe, 1);
    @(negedge clk) begin en = 1'b0; tx_mode = 1'b1; dr_wr = 1'b1; dr_wdata = 8'h00; end
    @(negedge clk) dr_wr = 1'b0;
    chk("R10", "scl released on disable", scl_oe, 0);
    chk("R10", "no sda drive on disable", sda_oe, 0);
    chk("R10", "irq dropped", irq, 0);
    chk("R10", "busy dropped", bus_busy, 0);
    m_stop();
    m_start();
    m_write_byte({OWN, 1'b0}, ack);
    chk("R10", "no ack while off", ack, 1);
    chk("R10", "busy stays 0 while off", bus_busy, 0);
    m_stop();
    en = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    en = 1'b1; tx_mode = 1'b0; ack_val = 1'b0; own_addr = OWN;
    dr_wdata = 8'h00; dr_wr = 1'b0; dr_rd = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    t_master_write();
    t_mismatch();
    t_master_read();
    t_restart_and_disable();
    finish_run();
  end
endmodule